// File: doc/BRIEF.md
# Secondary-Core Spin-Table Release Controller

This block keeps one boot-parameter record for each processor core of a multicore cluster. Each secondary core stays parked until boot software writes a usable entry address into its record. Software reaches the records over a small register bus that accepts byte, halfword and word accesses. Multi-byte values are packed most-significant byte first. The boot core's record and the records of cores that are not fitted can be read, but they cannot be changed.

Every record is 32 bytes long and is made of four fields:

- An entry address of 64 bits at byte 0. Bit 0 set means "keep waiting".
- A first argument of 64 bits at byte 8.
- A processor identifier of 32 bits at byte 20.
- Reserved space at bytes 16 and 24.

After each accepted write into a live record, the block checks bit 0 of that record's entry address. If the bit is clear, the block emits a single-cycle release request for that core. The request carries:

- the start program counter, which is the entry address reduced into a 64 MiB window;
- the window-aligned mapping base;
- the window size;
- the first argument.

In the same cycle, the record's identifier field is replaced by the core's real hardware identifier.

Top module: `spin_release_ctrl`

## Requirements
- R1: After reset, record i reads back entry address 1, first argument i and identifier i (reserved words 0), no release is pending and no response is valid.
- R2: Reads of size code 0 (1 byte), 1 (2 bytes) and 2 (4 bytes) return the addressed bytes right-justified in `rsp_rdata`, with the lowest address as the most significant byte; the record index is address bits [9:5].
- R3: Writes of 1, 2 or 4 bytes take data right-justified from `req_wdata` and change only the addressed bytes, lowest address receiving the most significant byte.
- R4: Writes into record 0 change nothing and never produce a release.
- R5: Writes into a record whose index is at or above CORE_CNT change nothing and never produce a release.
- R6: An accepted write into a live record that leaves entry-address bit 0 clear produces, in the cycle after acceptance, a one-cycle pulse on `rel_vec` with only the bit of that record set and `rel_idx` equal to the record index.
- R7: With the pulse, `rel_pc` equals the entry address modulo 2^26, `rel_base` equals the entry address with bits [25:0] cleared, `rel_arg` equals the record's first argument, and `rel_size` equals 2^26.
- R8: On a release, the record's identifier field (byte 20) takes the value of that core's 32-bit slice of `core_pid`.
- R9: Size code 3, an address not aligned to the access size, or an address at or beyond 1024 gives `rsp_err` high with `rsp_rdata` zero one cycle later; such a write changes nothing and releases nothing.
- R10: Every request is accepted at once, and `rsp_valid` is high exactly in the cycle after each acceptance; write responses carry zero data.
- R11: A record whose entry bit 0 is still clear is released again by any further accepted write to it, while a write that sets bit 0 produces no release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address inside the block |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 unsupported |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data, right-justified |
| rsp_err | output | 1 | Request was rejected |
| core_pid | input | CORE_CNT*32 | Hardware identifier of each present core, core k in bits [32k+31:32k] |
| rel_vec | output | SLOT_CNT | One-hot release pulse |
| rel_idx | output | log2(SLOT_CNT) | Index of the released core |
| rel_pc | output | 64 | Start program counter |
| rel_arg | output | 64 | First argument value |
| rel_base | output | 64 | Window-aligned mapping base |
| rel_size | output | 64 | Mapping window size |

## Verification
The properties assume that the bus side never issues more than one request per cycle. They also assume that `core_pid` stays steady while a release is being formed. The bench drives requests on falling edges, one at a time and with `req_valid` dropped between bursts, and it sets `core_pid` once before reset. The property that ties every release to a preceding write also assumes that requests are the only source of state changes. No other input is therefore toggled during the run.

// File: rtl/spin_pkg.sv
package spin_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   localparam int unsigned REC_BYTES  = 32;
   localparam int unsigned REC_WORDS  = 8;
   localparam int unsigned WD_ENT_HI  = 0;
   localparam int unsigned WD_ENT_LO  = 1;
   localparam int unsigned WD_ARG_HI  = 2;
   localparam int unsigned WD_ARG_LO  = 3;
   localparam int unsigned WD_PID     = 5;

   // initial content of one 32-bit word of record rec
   function automatic logic [31:0] init_word(int unsigned rec, int unsigned wd);
      case (wd)
         WD_ENT_LO: return 32'd1;
         WD_ARG_LO: return 32'(rec);
         WD_PID:    return 32'(rec);
         default:   return 32'd0;
      endcase
   endfunction

   // byte-lane merge, mask bit 3 = bits [31:24]
   function automatic logic [31:0] lane_merge(logic [31:0] old_w, logic [31:0] new_w,
                                              logic [3:0] m);
      logic [31:0] wide;
      wide = {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
      return (old_w & ~wide) | (new_w & wide);
   endfunction

endpackage

// File: rtl/spin_bus_decode.sv
module spin_bus_decode
   import spin_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned SLOT_CNT = 32,
   localparam int unsigned SLOT_IW = $clog2(SLOT_CNT),
   localparam int unsigned WIN_AW  = SLOT_IW + 5
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [1:0]         size,
   input  logic [31:0]        wdata,
   output logic               bad,
   output logic [SLOT_IW-1:0] slot,
   output logic [2:0]         word,
   output logic [3:0]         lane_mask,
   output logic [31:0]        wr_lanes,
   output logic [4:0]         rd_shift,
   output logic [31:0]        rd_mask
);

   logic [1:0] off;
   logic       misal;
   logic       in_win;

   assign off  = addr[1:0];
   assign word = addr[4:2];
   assign slot = addr[WIN_AW-1:5];

   generate
      if (ADDR_W > WIN_AW) begin : g_hi_bits
         assign in_win = (addr[ADDR_W-1:WIN_AW] == '0);
      end else begin : g_exact
         assign in_win = 1'b1;
      end
   endgenerate

   always_comb begin
      misal     = 1'b0;
      lane_mask = 4'b0000;
      wr_lanes  = wdata;
      rd_shift  = 5'd0;
      rd_mask   = 32'hFFFF_FFFF;
      unique case (acc_size_e'(size))
         SZ_BYTE: begin
            lane_mask = 4'b1000 >> off;
            wr_lanes  = {4{wdata[7:0]}};
            rd_shift  = {~off, 3'b000};
            rd_mask   = 32'h0000_00FF;
         end
         SZ_HALF: begin
            misal     = off[0];
            lane_mask = off[1] ? 4'b0011 : 4'b1100;
            wr_lanes  = {2{wdata[15:0]}};
            rd_shift  = {~off[1], 4'b0000};
            rd_mask   = 32'h0000_FFFF;
         end
         SZ_WORD: begin
            misal     = (off != 2'd0);
            lane_mask = 4'b1111;
         end
         default: begin
            misal     = 1'b1;
         end
      endcase
   end

   assign bad = misal | ~in_win;

endmodule

// File: rtl/spin_slot_store.sv
module spin_slot_store
   import spin_pkg::*;
#(
   parameter int unsigned SLOT_CNT = 32,
   localparam int unsigned SLOT_IW = $clog2(SLOT_CNT),
   localparam int unsigned FLAT_W  = SLOT_CNT * REC_WORDS * 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SLOT_IW-1:0] wr_slot,
   input  logic [2:0]         wr_word,
   input  logic [31:0]        wr_lanes,
   input  logic [3:0]         lane_mask,
   input  logic               pid_load,
   input  logic [31:0]        pid_value,
   input  logic [SLOT_IW-1:0] rd_slot,
   input  logic [2:0]         rd_word,
   output logic [31:0]        rd_data,
   output logic [63:0]        post_entry,
   output logic [63:0]        post_arg
);

   logic [FLAT_W-1:0] flat_q;

   generate
      for (genvar s = 0; s < SLOT_CNT; s++) begin : g_rec
         for (genvar w = 0; w < REC_WORDS; w++) begin : g_wd
            localparam logic [31:0] RST_VAL = init_word(s, w);
            logic [31:0] word_q;
            logic        hit;
            assign hit = wr_en && (wr_slot == SLOT_IW'(s)) && (wr_word == 3'(w));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  word_q <= RST_VAL;
               end else if (pid_load && (wr_slot == SLOT_IW'(s)) && (w == WD_PID)) begin
                  word_q <= pid_value;
               end else if (hit) begin
                  word_q <= lane_merge(word_q, wr_lanes, lane_mask);
               end
            end
            assign flat_q[(s*REC_WORDS+w)*32 +: 32] = word_q;
         end
      end
   endgenerate

   assign rd_data = flat_q[(int'(rd_slot)*REC_WORDS + int'(rd_word))*32 +: 32];

   // the four leading words of the written record, as they will be after the write
   logic [31:0] post_w [4];

   generate
      for (genvar k = 0; k < 4; k++) begin : g_post
         logic [31:0] old_w;
         assign old_w = flat_q[(int'(wr_slot)*REC_WORDS + k)*32 +: 32];
         assign post_w[k] = (wr_en && (wr_word == 3'(k)))
                            ? lane_merge(old_w, wr_lanes, lane_mask) : old_w;
      end
   endgenerate

   assign post_entry = {post_w[WD_ENT_HI], post_w[WD_ENT_LO]};
   assign post_arg   = {post_w[WD_ARG_HI], post_w[WD_ARG_LO]};

endmodule

// File: rtl/spin_release_gen.sv
module spin_release_gen #(
   parameter int unsigned SLOT_CNT = 32,
   parameter int unsigned WIN_LOG2 = 26,
   localparam int unsigned SLOT_IW = $clog2(SLOT_CNT),
   localparam logic [63:0] WIN_MASK = (64'd1 << WIN_LOG2) - 64'd1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic [SLOT_IW-1:0]  slot,
   input  logic [63:0]         entry,
   input  logic [63:0]         arg,
   output logic [SLOT_CNT-1:0] rel_vec,
   output logic [SLOT_IW-1:0]  rel_idx,
   output logic [63:0]         rel_pc,
   output logic [63:0]         rel_arg,
   output logic [63:0]         rel_base
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_vec <= '0;
      end else begin
         rel_vec <= fire ? (SLOT_CNT'(1) << slot) : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_idx  <= '0;
         rel_pc   <= '0;
         rel_arg  <= '0;
         rel_base <= '0;
      end else if (fire) begin
         rel_idx  <= slot;
         rel_pc   <= entry & WIN_MASK;
         rel_arg  <= arg;
         rel_base <= entry & ~WIN_MASK;
      end
   end

endmodule

// File: rtl/spin_release_ctrl.sv
module spin_release_ctrl
   import spin_pkg::*;
#(
   parameter int unsigned SLOT_CNT = 32,
   parameter int unsigned CORE_CNT = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned WIN_LOG2 = 26,
   localparam int unsigned SLOT_IW = $clog2(SLOT_CNT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [1:0]            req_size,
   input  logic [31:0]           req_wdata,
   output logic                  rsp_valid,
   output logic [31:0]           rsp_rdata,
   output logic                  rsp_err,
   input  logic [CORE_CNT*32-1:0] core_pid,
   output logic [SLOT_CNT-1:0]   rel_vec,
   output logic [SLOT_IW-1:0]    rel_idx,
   output logic [63:0]           rel_pc,
   output logic [63:0]           rel_arg,
   output logic [63:0]           rel_base,
   output logic [63:0]           rel_size
);

   generate
      if (SLOT_CNT < 2 || (SLOT_CNT & (SLOT_CNT - 1)) != 0) begin : g_bad_slots
         $error("SLOT_CNT must be a power of two, at least 2");
      end
      if (CORE_CNT < 1 || CORE_CNT > SLOT_CNT) begin : g_bad_cores
         $error("CORE_CNT must lie in 1..SLOT_CNT");
      end
      if (ADDR_W < SLOT_IW + 5) begin : g_bad_addr
         $error("ADDR_W too narrow for the record window");
      end
      if (WIN_LOG2 < 1 || WIN_LOG2 > 63) begin : g_bad_win
         $error("WIN_LOG2 out of range");
      end
   endgenerate

   logic               bad;
   logic [SLOT_IW-1:0] slot;
   logic [2:0]         word;
   logic [3:0]         lane_mask;
   logic [31:0]        wr_lanes;
   logic [4:0]         rd_shift;
   logic [31:0]        rd_mask;
   logic [31:0]        rd_raw;
   logic [63:0]        post_entry;
   logic [63:0]        post_arg;
   logic [SLOT_CNT*32-1:0] pid_pad;
   logic [31:0]        pid_sel;
   logic               accept;
   logic               live;
   logic               store_wr;
   logic               fire;

   assign req_ready = 1'b1;
   assign accept    = req_valid & req_ready;

   spin_bus_decode #(.ADDR_W(ADDR_W), .SLOT_CNT(SLOT_CNT)) u_dec (
      .addr      (req_addr),
      .size      (req_size),
      .wdata     (req_wdata),
      .bad       (bad),
      .slot      (slot),
      .word      (word),
      .lane_mask (lane_mask),
      .wr_lanes  (wr_lanes),
      .rd_shift  (rd_shift),
      .rd_mask   (rd_mask)
   );

   generate
      if (CORE_CNT < SLOT_CNT) begin : g_pad
         assign pid_pad = {{((SLOT_CNT-CORE_CNT)*32){1'b0}}, core_pid};
      end else begin : g_full
         assign pid_pad = core_pid;
      end
   endgenerate

   assign pid_sel  = pid_pad[int'(slot)*32 +: 32];
   assign live     = (slot != '0) && (int'(slot) < int'(CORE_CNT));
   assign store_wr = accept && req_write && !bad && live;
   assign fire     = store_wr && !post_entry[0];

   spin_slot_store #(.SLOT_CNT(SLOT_CNT)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (store_wr),
      .wr_slot    (slot),
      .wr_word    (word),
      .wr_lanes   (wr_lanes),
      .lane_mask  (lane_mask),
      .pid_load   (fire),
      .pid_value  (pid_sel),
      .rd_slot    (slot),
      .rd_word    (word),
      .rd_data    (rd_raw),
      .post_entry (post_entry),
      .post_arg   (post_arg)
   );

   spin_release_gen #(.SLOT_CNT(SLOT_CNT), .WIN_LOG2(WIN_LOG2)) u_rel (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .slot     (slot),
      .entry    (post_entry),
      .arg      (post_arg),
      .rel_vec  (rel_vec),
      .rel_idx  (rel_idx),
      .rel_pc   (rel_pc),
      .rel_arg  (rel_arg),
      .rel_base (rel_base)
   );

   assign rel_size = 64'd1 << WIN_LOG2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= accept;
         rsp_err   <= accept & bad;
         rsp_rdata <= (accept && !req_write && !bad) ? ((rd_raw >> rd_shift) & rd_mask) : 32'd0;
      end
   end

endmodule

// File: rtl/spin_release_chk.sv
module spin_release_chk #(
   parameter int unsigned SLOT_CNT = 32,
   parameter int unsigned CORE_CNT = 32,
   parameter int unsigned WIN_LOG2 = 26,
   localparam int unsigned SLOT_IW = $clog2(SLOT_CNT)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic                req_write,
   input logic                rsp_valid,
   input logic                rsp_err,
   input logic [31:0]         rsp_rdata,
   input logic [SLOT_CNT-1:0] rel_vec,
   input logic [SLOT_IW-1:0]  rel_idx,
   input logic [63:0]         rel_pc,
   input logic [63:0]         rel_base
);

   // R6
   rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rel_vec));

   // R6
   rel_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vec != '0) |-> rel_vec[rel_idx]);

   // R6
   rel_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vec != '0) |-> $past(req_valid && req_ready && req_write));

   // R4
   boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rel_vec[0]);

   // R5
   absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vec != '0) |-> (int'(rel_idx) < int'(CORE_CNT)));

   // R7
   pc_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vec != '0) |-> (rel_pc < (64'd1 << WIN_LOG2)));

   // R7
   base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vec != '0) |-> ((rel_base & ((64'd1 << WIN_LOG2) - 64'd1)) == 64'd0));

   // R9
   err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == 32'd0 && rsp_valid));

   // R10
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R10
   rsp_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid);

endmodule

bind spin_release_ctrl spin_release_chk #(
   .SLOT_CNT (SLOT_CNT),
   .CORE_CNT (CORE_CNT),
   .WIN_LOG2 (WIN_LOG2)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_write (req_write),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .rel_vec   (rel_vec),
   .rel_idx   (rel_idx),
   .rel_pc    (rel_pc),
   .rel_base  (rel_base)
);

// File: tb/spin_release_ctrl_bench.sv
`timescale 1ns/1ps
module spin_release_ctrl_bench;

   localparam int CORES = 6;
   localparam int SLOTS = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [11:0]       req_addr = '0;
   logic [1:0]        req_size = '0;
   logic [31:0]       req_wdata = '0;
   logic              rsp_valid;
   logic [31:0]       rsp_rdata;
   logic              rsp_err;
   logic [CORES*32-1:0] core_pid;
   logic [SLOTS-1:0]  rel_vec;
   logic [4:0]        rel_idx;
   logic [63:0]       rel_pc, rel_arg, rel_base, rel_size;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   always #4 clk = ~clk;

   spin_release_ctrl #(.SLOT_CNT(SLOTS), .CORE_CNT(CORES), .ADDR_W(12), .WIN_LOG2(26)) u_spin_release_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .core_pid(core_pid),
      .rel_vec(rel_vec), .rel_idx(rel_idx), .rel_pc(rel_pc), .rel_arg(rel_arg),
      .rel_base(rel_base), .rel_size(rel_size)
   );

   // byte-addressed behavioural model
   logic [7:0] mb [0:1023];

   function automatic logic [31:0] hw_id(int k);
      return 32'hA000_0000 + 32'(k * 16 + 3);
   endfunction

   function automatic bit is_bad(int a, int sz);
      if (sz == 3) return 1;
      if (a >= 1024) return 1;
      return (a % (1 << sz)) != 0;
   endfunction

   function automatic logic [31:0] m_read(int a, int sz);
      logic [31:0] r = 0;
      for (int k = 0; k < (1 << sz); k++) r = (r << 8) | 32'(mb[a + k]);
      return r;
   endfunction

   function automatic logic [63:0] m_get64(int a);
      logic [63:0] r = 0;
      for (int k = 0; k < 8; k++) r = (r << 8) | 64'(mb[a + k]);
      return r;
   endfunction

   task automatic m_write(int a, int sz, logic [31:0] d);
      int n = 1 << sz;
      for (int k = 0; k < n; k++) mb[a + k] = 8'(d >> (8 * (n - 1 - k)));
   endtask

   task automatic model_reset();
      for (int i = 0; i < 1024; i++) mb[i] = 8'h00;
      for (int s = 0; s < SLOTS; s++) begin
         mb[s*32 + 7]  = 8'h01;
         mb[s*32 + 15] = 8'(s);
         mb[s*32 + 23] = 8'(s);
      end
   endtask

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic xfer(bit wr, int a, int sz, logic [31:0] d, string tag);
      logic [31:0] exp_d = 0;
      bit exp_err, exp_rel = 0;
      int s = a / 32;
      logic [63:0] ent = 0, arg = 0;
      exp_err = is_bad(a, sz);
      if (!exp_err) begin
         if (!wr) exp_d = m_read(a, sz);
         else if (s != 0 && s < CORES) begin
            m_write(a, sz, d);
            if (mb[s*32 + 7][0] == 1'b0) begin
               exp_rel = 1;
               ent = m_get64(s*32);
               arg = m_get64(s*32 + 8);
               m_write(s*32 + 20, 2, hw_id(s));
            end
         end
      end
      req_valid = 1'b1; req_write = wr; req_addr = 12'(a);
      req_size = 2'(sz); req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 rsp_valid", 64'(rsp_valid), 64'd1);
      check({tag, " rsp_err"}, 64'(rsp_err), 64'(exp_err));
      check({tag, " rsp_rdata"}, 64'(rsp_rdata), 64'(exp_d));
      check({tag, " rel_vec"}, 64'(rel_vec), exp_rel ? (64'd1 << s) : 64'd0);
      if (exp_rel) begin
         check("R6 rel_idx", 64'(rel_idx), 64'(s));
         check("R7 rel_pc", rel_pc, ent & 64'h3FF_FFFF);
         check("R7 rel_base", rel_base, ent & ~64'h3FF_FFFF);
         check("R7 rel_arg", rel_arg, arg);
         check("R7 rel_size", rel_size, 64'h400_0000);
      end
   endtask

   task automatic idle(string tag);
      @(negedge clk);
      check({tag, " idle rsp_valid"}, 64'(rsp_valid), 64'd0);
      check({tag, " idle rel_vec"}, 64'(rel_vec), 64'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      for (int k = 0; k < CORES; k++) core_pid[k*32 +: 32] = hw_id(k);
      model_reset();
      repeat (3) @(negedge clk);
      check("R1 reset rel_vec", 64'(rel_vec), 64'd0);
      check("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset contents
      xfer(0, 'h004, 2, 0, "R1");
      xfer(0, 'h06C, 2, 0, "R1");
      xfer(0, 'h0B4, 2, 0, "R1");
      xfer(0, 'h3F4, 2, 0, "R1");
      xfer(0, 'h040, 2, 0, "R1");
      xfer(0, 'h050, 2, 0, "R1");
      // R2 narrow reads
      xfer(0, 'h3F7, 0, 0, "R2");
      xfer(0, 'h3F4, 0, 0, "R2");
      xfer(0, 'h3F6, 1, 0, "R2");
      xfer(0, 'h026, 1, 0, "R2");
      idle("R10");
      // R3 narrow writes
      xfer(1, 'h048, 2, 32'hCAFE_F00D, "R3");
      xfer(1, 'h049, 0, 32'hFFFF_FF11, "R3");
      xfer(1, 'h04A, 1, 32'hFFFF_2233, "R3");
      xfer(0, 'h048, 2, 0, "R3");
      xfer(0, 'h048, 0, 0, "R3");
      // R4 boot record
      xfer(1, 'h004, 2, 0, "R4");
      xfer(0, 'h004, 2, 0, "R4");
      xfer(1, 'h00C, 2, 32'h0000_FFFF, "R4");
      xfer(0, 'h00C, 2, 0, "R4");
      // R5 absent cores
      xfer(1, 'h0C4, 2, 0, "R5");
      xfer(0, 'h0C4, 2, 0, "R5");
      xfer(1, 'h3E4, 2, 0, "R5");
      xfer(0, 'h3E4, 2, 0, "R5");
      // R6 R7 release of record 3
      xfer(1, 'h060, 2, 32'h0000_0001, "R6");
      xfer(1, 'h06C, 2, 32'h1234_5678, "R6");
      xfer(1, 'h064, 2, 32'h0ABC_DEF0, "R6");
      // R8 identifier replaced
      xfer(0, 'h074, 2, 0, "R8");
      // R11 re-release and re-park
      xfer(1, 'h06F, 0, 32'h0000_0099, "R11");
      xfer(1, 'h067, 0, 32'h0000_00F1, "R11");
      xfer(0, 'h064, 2, 0, "R11");
      idle("R11");
      // R3 R6 halfword write releases record 4
      xfer(1, 'h086, 1, 32'h0000_1234, "R6");
      xfer(0, 'h094, 2, 0, "R8");
      // R6 boundary records 5 and 1
      xfer(1, 'h0A4, 2, 32'hFC00_0004, "R6");
      xfer(1, 'h027, 0, 32'h0000_0000, "R6");
      xfer(0, 'h034, 2, 0, "R8");
      // R9 rejected accesses
      xfer(0, 'h000, 3, 0, "R9");
      xfer(0, 'h043, 1, 0, "R9");
      xfer(0, 'h042, 2, 0, "R9");
      xfer(0, 'h400, 2, 0, "R9");
      xfer(1, 'h045, 2, 0, "R9");
      xfer(1, 'h044, 3, 0, "R9");
      xfer(1, 'h404, 2, 0, "R9");
      xfer(0, 'h044, 2, 0, "R9");
      idle("R9");
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

endmodule